// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Private Result Registers

This block is a sequential arithmetic unit that sits beside a core's main ALU. It handles 32-bit signed and unsigned multiplication and division and keeps its results in two dedicated registers, HI and LO, rather than in the register file. The core gives it one instruction per cycle on a small issue port. Each instruction carries a function code and two operands.

A multiply or divide starts a run of one setup cycle and 32 radix-2 iteration cycles, and `busy` is high for that whole run. The core reads a result with a move-from-HI or move-from-LO request. If that request arrives while an operation is still running, the unit raises `stall` and the core holds the request until the data is ready. Only these reads are interlocked. Other instructions keep flowing, and a new multiply or divide that arrives while one is running cancels it and starts over.

The unit also watches the instruction stream for a start that comes too soon after a result read. It flags that case on `hazard` but still executes the start.

Top module: `muldiv_hilo`

## Requirements
- R1: While `rst_n` is low and after reset, HI and LO hold 0, and `busy`, `stall`, `rd_vld`, `hazard` and `rd_data` are 0.
- R2: Function code 0x18 multiplies the operands as signed 32-bit values. The upper 32 bits of the 64-bit product go to HI and the lower 32 bits go to LO.
- R3: Function code 0x19 forms the unsigned 64-bit product, with the upper half in HI and the lower half in LO.
- R4: Function code 0x1A divides signed operands. LO receives the quotient truncated toward zero and HI receives the remainder, which takes the dividend's sign. The case 0x80000000 / -1 gives quotient 0x80000000 and remainder 0.
- R5: Function code 0x1B divides unsigned operands, with the quotient in LO and the remainder in HI.
- R6: `busy` rises in the cycle after a start is accepted and stays high for exactly 33 cycles. HI and LO take the new values at the edge where `busy` falls.
- R7: Function code 0x10 reads HI and 0x12 reads LO. While `busy` is high, such a request raises `stall` in the same cycle, and `rd_vld` stays 0 with `rd_data` at 0. While `busy` is low, the request raises `rd_vld` in the same cycle and `rd_data` carries the selected register.
- R8: A start that arrives while `busy` is high cancels the running operation without writing HI or LO. The new operation then completes 33 cycles later with results from the new operands.
- R9: Division by zero completes in the normal 33 cycles and raises no error or stall. Afterwards the unit accepts further work normally.
- R10: `hazard` is high in the same cycle as a start, if fewer than two accepted instructions have separated that start from the last accepted HI/LO read. Idle cycles and stalled reads do not count as instructions. The flagged operation still executes.
- R11: Any other function code is accepted without effect. HI and LO change only when an operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An instruction is presented this cycle |
| issue_funct | input | 6 | Function code of the presented instruction |
| src_a | input | 32 | First operand (multiplicand or dividend) |
| src_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | An operation is in progress |
| stall | output | 1 | The presented HI/LO read must be held |
| rd_vld | output | 1 | `rd_data` carries the requested register |
| rd_data | output | 32 | HI or LO read data, 0 when not valid |
| hazard | output | 1 | A start came too soon after a result read |

## Verification
The multipliers and dividers are driven with these patterns:
- Small mixed-sign values, which expose sign-correction mistakes.
- The most negative value and all-ones values, which push carries and borrows into the top bit and separate the signed opcodes from the unsigned ones.
- The 0x80000000 / -1 quotient.
- Divisors larger than half the range, which exercise the extra remainder bit in the shift-subtract step.
- Division by zero.
- A spread of pseudo-random operands.

Restarts are placed early in a run and at the final iteration cycle, to show that a cancelled operation never writes HI or LO. Result reads are issued both while an operation runs and after it ends. Starts are placed one, two and three instructions after a read, so that the hazard window edge is exercised on both sides.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam logic [5:0] FN_RD_HI  = 6'h10;
  localparam logic [5:0] FN_RD_LO  = 6'h12;
  localparam logic [5:0] FN_MUL_S  = 6'h18;
  localparam logic [5:0] FN_MUL_U  = 6'h19;
  localparam logic [5:0] FN_DIV_S  = 6'h1A;
  localparam logic [5:0] FN_DIV_U  = 6'h1B;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} eng_state_t;
  typedef enum logic [1:0] {K_MUL_S, K_MUL_U, K_DIV_S, K_DIV_U} op_kind_t;

  function automatic logic fn_starts(input logic [5:0] f);
    return (f == FN_MUL_S) || (f == FN_MUL_U) || (f == FN_DIV_S) || (f == FN_DIV_U);
  endfunction

  function automatic logic fn_reads(input logic [5:0] f);
    return (f == FN_RD_HI) || (f == FN_RD_LO);
  endfunction

  function automatic op_kind_t fn_kind(input logic [5:0] f);
    case (f)
      FN_MUL_U: return K_MUL_U;
      FN_DIV_S: return K_DIV_S;
      FN_DIV_U: return K_DIV_U;
      default:  return K_MUL_S;
    endcase
  endfunction
endpackage

// File: rtl/muldiv_engine.sv
module muldiv_engine
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  op_kind_t     kind,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  // One shift-add multiply step on {partial product, remaining multiplier}.
  function automatic logic [2*W-1:0] mul_step(input logic [2*W-1:0] p, input logic [W-1:0] m);
    logic [W:0] sum;
    sum = {1'b0, p[2*W-1:W]} + (p[0] ? {1'b0, m} : {(W+1){1'b0}});
    return {sum, p[W-1:1]};
  endfunction

  // One restoring shift-subtract divide step on {remainder, quotient}.
  function automatic logic [2*W-1:0] div_step(input logic [2*W-1:0] p, input logic [W-1:0] d);
    logic [2*W-1:0] s;
    logic [W:0]     t;
    s = {p[2*W-2:0], 1'b0};
    t = {p[2*W-1], s[2*W-1:W]} - {1'b0, d};
    if (!t[W]) s = {t[W-1:0], s[W-1:1], 1'b1};
    return s;
  endfunction

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic sgn);
    return (sgn && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  eng_state_t     st;
  logic [CW-1:0]  cnt;
  op_kind_t       kind_q;
  logic [W-1:0]   a_q, b_q, dvs;
  logic [2*W-1:0] acc, acc_nx, prod_fix;
  logic           neg_hi, neg_lo;
  logic           is_mul, is_sgn;

  assign is_mul = (kind_q == K_MUL_S) || (kind_q == K_MUL_U);
  assign is_sgn = (kind_q == K_MUL_S) || (kind_q == K_DIV_S);
  assign acc_nx = is_mul ? mul_step(acc, dvs) : div_step(acc, dvs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      kind_q <= K_MUL_S;
      a_q    <= '0;
      b_q    <= '0;
      dvs    <= '0;
      acc    <= '0;
      neg_hi <= 1'b0;
      neg_lo <= 1'b0;
    end else if (go) begin
      st     <= ST_SETUP;
      cnt    <= '0;
      kind_q <= kind;
      a_q    <= opa;
      b_q    <= opb;
    end else begin
      case (st)
        ST_SETUP: begin
          acc    <= {{W{1'b0}}, magnitude(a_q, is_sgn)};
          dvs    <= magnitude(b_q, is_sgn);
          neg_lo <= is_sgn && (a_q[W-1] ^ b_q[W-1]);
          neg_hi <= is_sgn && (is_mul ? (a_q[W-1] ^ b_q[W-1]) : a_q[W-1]);
          cnt    <= '0;
          st     <= ST_RUN;
        end
        ST_RUN: begin
          acc <= acc_nx;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_RUN) && (cnt == LAST) && !go;
  assign prod_fix = neg_lo ? (~acc_nx + 1'b1) : acc_nx;

  always_comb begin
    if (is_mul) begin
      res_hi = prod_fix[2*W-1:W];
      res_lo = prod_fix[W-1:0];
    end else begin
      res_lo = neg_lo ? (~acc_nx[W-1:0] + 1'b1) : acc_nx[W-1:0];
      res_hi = neg_hi ? (~acc_nx[2*W-1:W] + 1'b1) : acc_nx[2*W-1:W];
    end
  end
endmodule

// File: rtl/muldiv_hazard.sv
module muldiv_hazard #(
  parameter int WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic is_read,
  input  logic is_start,
  output logic hazard
);
  localparam int HW = $clog2(WIN + 1);
  localparam logic [HW-1:0] FULL = HW'(WIN);

  logic [HW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)                        left <= '0;
    else if (accept && is_read)        left <= FULL;
    else if (accept && left != '0)     left <= left - 1'b1;
  end

  assign hazard = is_start && (left != '0);
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W       = 32,
  parameter int HAZ_WIN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue_vld,
  input  logic [5:0]   issue_funct,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic         stall,
  output logic         rd_vld,
  output logic [W-1:0] rd_data,
  output logic         hazard
);
  logic         start_acc, read_req, accept, eng_done;
  logic [W-1:0] hi_q, lo_q, res_hi, res_lo;

  assign start_acc = issue_vld && fn_starts(issue_funct);
  assign read_req  = issue_vld && fn_reads(issue_funct);
  assign stall     = read_req && busy;
  assign accept    = issue_vld && !stall;
  assign rd_vld    = read_req && !busy;
  assign rd_data   = !rd_vld ? '0 : ((issue_funct == FN_RD_HI) ? hi_q : lo_q);

  muldiv_engine #(.W(W)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (start_acc),
    .kind   (fn_kind(issue_funct)),
    .opa    (src_a),
    .opb    (src_b),
    .busy   (busy),
    .done   (eng_done),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  muldiv_hazard #(.WIN(HAZ_WIN)) u_haz (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .is_read  (read_req),
    .is_start (start_acc),
    .hazard   (hazard)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (eng_done) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end
  end
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue_vld,
  input logic         busy,
  input logic         stall,
  input logic         rd_vld,
  input logic         hazard,
  input logic         start_acc,
  input logic         eng_done,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);
  p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !busy);
  p_done_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> busy);
  p_stall_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (busy && issue_vld && !rd_vld));
  p_read_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> !busy);
  p_restart_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && busy) |-> !eng_done);
  p_hazard_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> start_acc);
  p_hazard_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |=> (start_acc |-> hazard));
  p_hilo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_done |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_vld (issue_vld),
  .busy      (busy),
  .stall     (stall),
  .rd_vld    (rd_vld),
  .hazard    (hazard),
  .start_acc (start_acc),
  .eng_done  (eng_done),
  .hi_q      (hi_q),
  .lo_q      (lo_q)
);

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_vld = 1'b0;
  logic [5:0]  issue_funct = 6'h00;
  logic [31:0] src_a = '0, src_b = '0;
  logic        busy, stall, rd_vld, hazard;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  muldiv_hilo uut (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_funct(issue_funct),
    .src_a(src_a), .src_b(src_b), .busy(busy), .stall(stall),
    .rd_vld(rd_vld), .rd_data(rd_data), .hazard(hazard)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit          m_busy, m_unk, p_unk;
  int          m_cnt, m_win;
  logic [31:0] m_hi, m_lo, p_hi, p_lo;
  string       m_tag = "R1", p_tag = "R1";

  function automatic bit f_start(logic [5:0] f);
    return f == 6'h18 || f == 6'h19 || f == 6'h1A || f == 6'h1B;
  endfunction
  function automatic bit f_read(logic [5:0] f);
    return f == 6'h10 || f == 6'h12;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_win = 0; m_hi = 0; m_lo = 0; m_unk = 0;
    end else begin
      bit rd, st, acc;
      rd  = issue_vld && f_read(issue_funct);
      st  = issue_vld && f_start(issue_funct);
      acc = issue_vld && !(rd && m_busy);
      if (st) begin
        logic signed [63:0] sa, sb, sp;
        logic [63:0] up;
        sa = {{32{src_a[31]}}, src_a};
        sb = {{32{src_b[31]}}, src_b};
        p_unk = 0;
        p_tag = m_busy ? "R8" : (issue_funct == 6'h18 ? "R2" : issue_funct == 6'h19 ? "R3" :
                                 issue_funct == 6'h1A ? "R4" : "R5");
        case (issue_funct)
          6'h18: begin sp = sa * sb; p_hi = sp[63:32]; p_lo = sp[31:0]; end
          6'h19: begin up = {32'b0, src_a} * {32'b0, src_b}; p_hi = up[63:32]; p_lo = up[31:0]; end
          6'h1A: if (src_b == 0) p_unk = 1;
                 else begin sp = sa / sb; p_lo = sp[31:0]; sp = sa % sb; p_hi = sp[31:0]; end
          default: if (src_b == 0) p_unk = 1;
                   else begin p_lo = src_a / src_b; p_hi = src_a % src_b; end
        endcase
        m_busy = 1; m_cnt = 33;
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_hi = p_hi; m_lo = p_lo; m_unk = p_unk; m_tag = p_unk ? "R9" : p_tag;
        end
      end
      if (acc && rd) m_win = 2;
      else if (acc && m_win > 0) m_win--;
    end
  end

  // lockstep comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit rd, st, e_stall, e_vld, e_haz;
      logic [31:0] e_data;
      rd = issue_vld && f_read(issue_funct);
      st = issue_vld && f_start(issue_funct);
      e_stall = rd && m_busy;
      e_vld   = rd && !m_busy;
      e_haz   = st && (m_win > 0);
      e_data  = !e_vld ? 32'h0 : (issue_funct == 6'h10 ? m_hi : m_lo);
      chk(busy == m_busy, "R6 busy", busy, m_busy);
      chk(stall == e_stall, "R7 stall", stall, e_stall);
      chk(rd_vld == e_vld, "R7 rd_vld", rd_vld, e_vld);
      chk(hazard == e_haz, "R10 hazard", hazard, e_haz);
      if (!(e_vld && m_unk))
        chk(rd_data == e_data, {m_tag, " rd_data"}, rd_data, e_data);
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input bit v, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk); #1;
    issue_vld = v; issue_funct = f; src_a = a; src_b = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 6'h00, 0, 0);
  endtask

  // start, then hold a HI read across the run, then read LO
  task automatic op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    put(1, f, a, b);
    idle(2);
    for (int i = 0; i < 34; i++) put(1, 6'h10, 0, 0);
    put(1, 6'h12, 0, 0);
    put(1, 6'h00, 0, 0);
    put(1, 6'h00, 0, 0);
    idle(1);
  endtask

  bit wd_fired = 0;
  initial begin
    #(8 * 150000);
    wd_fired = 1;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!busy && !stall && !rd_vld && !hazard && rd_data == 0, "R1 reset outputs",
        {busy, stall, rd_vld, hazard}, 0);
    @(posedge clk); #1 rst_n = 1;
    put(1, 6'h10, 0, 0);
    @(negedge clk); chk(rd_vld && rd_data == 0, "R1 HI after reset", rd_data, 0);
    put(1, 6'h12, 0, 0);
    @(negedge clk); chk(rd_vld && rd_data == 0, "R1 LO after reset", rd_data, 0);
    idle(1);

    op(6'h18, 32'hFFFF_FFFD, 32'd7);           // R2 mixed sign
    op(6'h18, 32'h8000_0000, 32'h8000_0000);   // R2 most negative squared
    op(6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R2
    op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R3 unsigned
    op(6'h19, 32'h8000_0001, 32'h0001_0000);   // R3
    op(6'h1A, 32'hFFFF_FFF9, 32'd2);           // R4 -7/2
    op(6'h1A, 32'd7, 32'hFFFF_FFFE);           // R4 7/-2
    op(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF);   // R4 overflow quotient
    op(6'h1B, 32'hFFFF_FFFF, 32'd3);           // R5
    op(6'h1B, 32'd5, 32'd7);                   // R5
    op(6'h1B, 32'hF000_0000, 32'hC000_0001);   // R5 large divisor

    // R9: divide by zero, then normal work
    op(6'h1A, 32'd123, 32'd0);
    op(6'h1B, 32'd99, 32'd0);
    op(6'h18, 32'd6, 32'd9);

    // R8: restart early and at the final iteration
    put(1, 6'h18, 32'd1000, 32'd1000);
    idle(9);
    op(6'h1A, 32'hFFFF_FF9C, 32'd7);
    put(1, 6'h19, 32'h1234_5678, 32'h9ABC_DEF0);
    idle(32);
    op(6'h1B, 32'd1000, 32'd33);

    // R10: window edges (read, one instruction, start -> flagged)
    put(1, 6'h12, 0, 0); put(1, 6'h00, 0, 0); put(1, 6'h19, 32'd3, 32'd4);
    @(negedge clk); chk(hazard == 1, "R10 start two slots after read", hazard, 1);
    idle(40);
    put(1, 6'h12, 0, 0); put(1, 6'h00, 0, 0); put(1, 6'h00, 0, 0); put(1, 6'h19, 32'd5, 32'd6);
    @(negedge clk); chk(hazard == 0, "R10 start three slots after read", hazard, 0);
    idle(2);
    put(1, 6'h12, 0, 0);  // stalled read does not count
    put(1, 6'h18, 32'd2, 32'd2);
    @(negedge clk); chk(hazard == 0, "R10 stalled read ignored", hazard, 0);
    idle(40);

    // R11: unrelated function code has no effect
    put(1, 6'h20, 32'hDEAD_BEEF, 32'h1);
    @(negedge clk); chk(busy == 0, "R11 other funct no start", busy, 0);
    idle(3);
    put(1, 6'h12, 0, 0);
    @(negedge clk); chk(rd_data == 32'd4, "R11 LO unchanged", rd_data, 4);
    idle(1);

    for (int i = 0; i < 16; i++) begin
      logic [5:0] f;
      f = 6'h18 + 6'(i % 4);
      if (f == 6'h1A) f = 6'h1A;
      op(f, $urandom, (i % 5 == 0) ? ($urandom >> (i % 31)) : $urandom);
    end

    idle(3);
    if (!wd_fired) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule